// File: doc/BRIEF.md
# UART Character Buffers and Poll Flags

This block holds the characters waiting to be sent and the characters already received by a UART, and it produces the flag word that driver software polls before it writes or reads a character. The host writes TX characters with a strobe and reads RX characters with a strobe. The line side pops TX characters into its shifter, reports whether that shifter is still active, and pushes received characters together with their error bits.

A single mode bit, `fifo_en_i`, sets the capacity of both directions. When it is set, each direction is a 16-entry queue. When it is clear, each direction holds a single character. Every flag follows the storage selected by the current mode. The busy flag covers both the queued TX characters and the shifter, so software can wait on it to know the line has gone quiet. Clearing the mode bit discards any TX characters that are still queued.

Top module: `uart_buf_flags`

## Requirements
- R1: The flag word uses these bit positions: bit 7 = TX-empty, bit 6 = RX-full, bit 5 = TX-full, bit 4 = RX-empty, bit 3 = busy, and bits 2..0 always read 0. After reset the word is 8'h90 and `overrun_o` is 0.
- R2: With `fifo_en_i`=1, the TX store holds 16 characters. TX-full reads 1 exactly when 16 characters are held, and TX-empty reads 1 exactly when none are held.
- R3: With `fifo_en_i`=0, the TX store holds a single character. TX-full reads 1 as soon as one character is held.
- R4: With `fifo_en_i`=1 the RX store holds 16 entries, and with `fifo_en_i`=0 it holds one. RX-full and RX-empty follow that capacity in the same way as the TX flags.
- R5: TX-empty describes only the TX store. It reads 1 while `tx_shift_busy_i` is 1 if no character is stored.
- R6: Busy reads 1 in the cycle after any edge at which the TX store is non-empty after the edge or `tx_shift_busy_i` is 1. It reads 0 only when both conditions are false.
- R7: A 1-to-0 change of `fifo_en_i` empties the TX store at that edge. Afterwards TX-empty reads 1, and the next character written is the next one popped.
- R8: A TX write while TX-full reads 1 is dropped. The stored contents and their order are unchanged.
- R9: An RX read while RX-empty reads 1 leaves `rx_rdata_o` at its previous value and leaves the flags unchanged.
- R10: An RX push while RX-full reads 1 is discarded and sets `overrun_o`. `overrun_o` stays 1 until an `ovr_clr_i` strobe. If a discard and a clear happen in the same cycle, the flag is set.
- R11: Every flag is registered. A flag changes on the clock edge that samples the strobe that affects it, and is visible in the cycle that follows that edge.
- R12: Both stores are first-in first-out. Popped TX data appears on `tx_pop_data_o`, and read RX data appears on `rx_rdata_o`, in the cycle after the pop or read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | 1 selects 16-entry queues, 0 selects single holding registers |
| tx_wr_i | input | 1 | Host TX write strobe |
| tx_wdata_i | input | 8 | Host TX character |
| tx_pop_i | input | 1 | Line side takes the oldest TX character |
| tx_pop_data_o | output | 8 | TX character taken by the last pop |
| tx_shift_busy_i | input | 1 | TX shifter is still sending a character |
| rx_push_i | input | 1 | Line side delivers a received entry |
| rx_push_data_i | input | 12 | Received entry: error bits 11..8, data bits 7..0 |
| rx_rd_i | input | 1 | Host RX read strobe |
| rx_rdata_o | output | 12 | RX entry returned by the last read |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| overrun_o | output | 1 | Sticky flag: an RX entry was discarded |
| flags_o | output | 8 | Packed poll flag word |

## Verification
The bench builds the block with its default parameters: 16-entry queues, 8-bit TX entries and 12-bit RX entries. At that depth both queues can be filled to the limit in a few dozen cycles. The bench then overflows each queue by one entry and drains it again, so the full boundary, the dropped writes, the discarded pushes and the first-in first-out order are all observed. Switching the mode bit between runs also covers the single-register capacity, the TX flush on a falling mode bit, and the difference between busy and TX-empty while the shifter is active.

// File: rtl/uart_buf_pkg.sv
package uart_buf_pkg;
  parameter int unsigned FIFO_DEPTH = 16;
  parameter int unsigned TX_W       = 8;
  parameter int unsigned RX_W       = 12;
  parameter int unsigned FLAG_W     = 8;

  // Flag word bit positions (software decodes these)
  parameter int unsigned BIT_TXE  = 7;
  parameter int unsigned BIT_RXF  = 6;
  parameter int unsigned BIT_TXF  = 5;
  parameter int unsigned BIT_RXE  = 4;
  parameter int unsigned BIT_BUSY = 3;

  typedef struct packed {
    logic tx_empty;
    logic rx_full;
    logic tx_full;
    logic rx_empty;
    logic busy;
    logic [2:0] zero;
  } flag_word_t;
endpackage

// File: rtl/uart_buf_store.sv
module uart_buf_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fifo_en_i,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         empty_next_o,
  output logic         drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_q, count_d, cap;
  logic          full_q, empty_q;
  logic          push_ok, pop_ok;
  logic [W-1:0]  rdata_q;

  // Accept decisions follow the flags software sees
  assign push_ok = push_i & ~full_q & ~flush_i;
  assign pop_ok  = pop_i & ~empty_q;
  assign cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);

  always_comb begin
    if (flush_i) begin
      count_d  = '0;
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      count_d  = count_q + CW'(push_ok) - CW'(pop_ok);
      wr_ptr_d = wr_ptr;
      rd_ptr_d = rd_ptr;
      if (push_ok) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      count_q <= count_d;
      wr_ptr  <= wr_ptr_d;
      rd_ptr  <= rd_ptr_d;
      full_q  <= (count_d >= cap);
      empty_q <= (count_d == '0);
    end
  end

  // Storage array: no reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end

  // Synchronous read port, holds on an empty pop
  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (pop_ok) rdata_q <= mem[rd_ptr];
  end

  assign pop_data_o   = rdata_q;
  assign full_o       = full_q;
  assign empty_o      = empty_q;
  assign empty_next_o = (count_d == '0);
  assign drop_o       = push_i & full_q;
endmodule

// File: rtl/uart_flag_gen.sv
module uart_flag_gen
  import uart_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic              tx_empty_next_i,
  input  logic              shift_busy_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_drop_i,
  input  logic              ovr_clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              overrun_o
);
  logic busy_q, ovr_q;
  flag_word_t word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= ~tx_empty_next_i | shift_busy_i;
      if (rx_drop_i)      ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    word.tx_empty = tx_empty_i;
    word.rx_full  = rx_full_i;
    word.tx_full  = tx_full_i;
    word.rx_empty = rx_empty_i;
    word.busy     = busy_q;
    word.zero     = 3'b000;
  end

  assign flags_o   = word;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_buf_flags.sv
module uart_buf_flags
  import uart_buf_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned TXW   = TX_W,
  parameter int unsigned RXW   = RX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en_i,
  input  logic              tx_wr_i,
  input  logic [TXW-1:0]    tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [TXW-1:0]    tx_pop_data_o,
  input  logic              tx_shift_busy_i,
  input  logic              rx_push_i,
  input  logic [RXW-1:0]    rx_push_data_i,
  input  logic              rx_rd_i,
  output logic [RXW-1:0]    rx_rdata_o,
  input  logic              ovr_clr_i,
  output logic              overrun_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic fifo_en_q, tx_flush;
  logic tx_full, tx_empty, tx_empty_next, tx_drop_unused;
  logic rx_full, rx_empty, rx_empty_next_unused, rx_drop;

  always_ff @(posedge clk) begin
    if (rst) fifo_en_q <= 1'b0;
    else     fifo_en_q <= fifo_en_i;
  end

  // Falling mode bit discards queued TX characters
  assign tx_flush = fifo_en_q & ~fifo_en_i;

  uart_buf_store #(.W(TXW), .DEPTH(DEPTH)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .fifo_en_i    (fifo_en_i),
    .flush_i      (tx_flush),
    .push_i       (tx_wr_i),
    .push_data_i  (tx_wdata_i),
    .pop_i        (tx_pop_i),
    .pop_data_o   (tx_pop_data_o),
    .full_o       (tx_full),
    .empty_o      (tx_empty),
    .empty_next_o (tx_empty_next),
    .drop_o       (tx_drop_unused)
  );

  uart_buf_store #(.W(RXW), .DEPTH(DEPTH)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .fifo_en_i    (fifo_en_i),
    .flush_i      (1'b0),
    .push_i       (rx_push_i),
    .push_data_i  (rx_push_data_i),
    .pop_i        (rx_rd_i),
    .pop_data_o   (rx_rdata_o),
    .full_o       (rx_full),
    .empty_o      (rx_empty),
    .empty_next_o (rx_empty_next_unused),
    .drop_o       (rx_drop)
  );

  uart_flag_gen u_flags (
    .clk             (clk),
    .rst             (rst),
    .tx_full_i       (tx_full),
    .tx_empty_i      (tx_empty),
    .tx_empty_next_i (tx_empty_next),
    .shift_busy_i    (tx_shift_busy_i),
    .rx_full_i       (rx_full),
    .rx_empty_i      (rx_empty),
    .rx_drop_i       (rx_drop),
    .ovr_clr_i       (ovr_clr_i),
    .flags_o         (flags_o),
    .overrun_o       (overrun_o)
  );

  logic unused_ok;
  assign unused_ok = tx_drop_unused ^ rx_empty_next_unused;
endmodule

// File: rtl/uart_buf_flags_chk.sv
module uart_buf_flags_chk #(
  parameter int unsigned RXW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           fifo_en_i,
  input logic           tx_wr_i,
  input logic           tx_pop_i,
  input logic           rx_push_i,
  input logic           rx_rd_i,
  input logic [RXW-1:0] rx_rdata_o,
  input logic           ovr_clr_i,
  input logic           overrun_o,
  input logic [7:0]     flags_o
);
  // R2: TX full and TX empty never both set
  p_tx_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(flags_o[7] && flags_o[5]));

  // R4: RX full and RX empty never both set
  p_rx_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(flags_o[6] && flags_o[4]));

  // R6: a non-empty TX store always shows busy
  p_busy_cover_r6: assert property (@(posedge clk) disable iff (rst)
    !flags_o[7] |-> flags_o[3]);

  // R7: falling mode bit leaves TX empty
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_en_i) |=> flags_o[7]);

  // R8: dropped write keeps TX full
  p_drop_write_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_i && flags_o[5] && !tx_pop_i && fifo_en_i == $past(fifo_en_i)) |=> flags_o[5]);

  // R9: read on empty RX changes nothing
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_rd_i && flags_o[4] && !rx_push_i) |=> ($stable(rx_rdata_o) && flags_o[4]));

  // R10: discarded push raises overrun
  p_overrun_set_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_push_i && flags_o[6] && !rx_rd_i) |=> overrun_o);

  // R10: overrun is sticky without a clear
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !ovr_clr_i) |=> overrun_o);
endmodule

bind uart_buf_flags uart_buf_flags_chk #(.RXW(RXW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en_i  (fifo_en_i),
  .tx_wr_i    (tx_wr_i),
  .tx_pop_i   (tx_pop_i),
  .rx_push_i  (rx_push_i),
  .rx_rd_i    (rx_rd_i),
  .rx_rdata_o (rx_rdata_o),
  .ovr_clr_i  (ovr_clr_i),
  .overrun_o  (overrun_o),
  .flags_o    (flags_o)
);

// File: tb/sim_uart_buf_flags.sv
module sim_uart_buf_flags;
  localparam logic [7:0] TXE = 8'h80, RXF = 8'h40, TXF = 8'h20, RXE = 8'h10, BSY = 8'h08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en_i = 1'b1;
  logic        tx_wr_i = 1'b0;
  logic [7:0]  tx_wdata_i = '0;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_pop_data_o;
  logic        tx_shift_busy_i = 1'b0;
  logic        rx_push_i = 1'b0;
  logic [11:0] rx_push_data_i = '0;
  logic        rx_rd_i = 1'b0;
  logic [11:0] rx_rdata_o;
  logic        ovr_clr_i = 1'b0;
  logic        overrun_o;
  logic [7:0]  flags_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_buf_flags u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic tx_write(logic [7:0] d);
    tx_wr_i = 1'b1; tx_wdata_i = d; tick(); tx_wr_i = 1'b0;
  endtask

  task automatic tx_take(bit shift);
    tx_pop_i = 1'b1; tx_shift_busy_i = shift; tick(); tx_pop_i = 1'b0;
  endtask

  task automatic rx_put(logic [11:0] d);
    rx_push_i = 1'b1; rx_push_data_i = d; tick(); rx_push_i = 1'b0;
  endtask

  task automatic rx_take();
    rx_rd_i = 1'b1; tick(); rx_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "flags after reset", flags_o, TXE | RXE);
    check("R1", "overrun after reset", overrun_o, 0);
  endtask

  task automatic t_tx_fifo();
    fifo_en_i = 1'b1; tick();
    tx_write(8'h01);
    check("R11", "flags after first write", flags_o, RXE | BSY);
    for (int i = 1; i < 16; i++) tx_write(8'(i * 3 + 1));
    check("R2", "flags at 16 entries", flags_o, TXF | RXE | BSY);
    tx_write(8'hEE);
    check("R8", "flags after dropped write", flags_o, TXF | RXE | BSY);
    for (int i = 0; i < 16; i++) begin
      tx_take(1'b0);
      check("R12", "tx pop order", tx_pop_data_o, 8'(i * 3 + 1));
      if (i == 0) check("R2", "full clears after one pop", flags_o, RXE | BSY);
    end
    check("R6", "empty and idle after drain", flags_o, TXE | RXE);
  endtask

  task automatic t_tx_single();
    fifo_en_i = 1'b0; tick();
    tx_write(8'h5A);
    check("R3", "single register full", flags_o, TXF | RXE | BSY);
    tx_write(8'h11);
    tx_take(1'b0);
    check("R8", "dropped write not stored", tx_pop_data_o, 8'h5A);
    check("R3", "single register empty", flags_o, TXE | RXE);
  endtask

  task automatic t_shift();
    tx_write(8'hA5);
    tx_take(1'b1);
    check("R5", "tx empty while shifting", flags_o, TXE | RXE | BSY);
    tick(); tick();
    check("R6", "busy held by shifter", flags_o, TXE | RXE | BSY);
    tx_shift_busy_i = 1'b0; tick();
    check("R6", "busy drops after shifter", flags_o, TXE | RXE);
  endtask

  task automatic t_flush();
    fifo_en_i = 1'b1; tick();
    for (int i = 0; i < 5; i++) tx_write(8'hC0 + 8'(i));
    check("R2", "five queued", flags_o, RXE | BSY);
    fifo_en_i = 1'b0; tick();
    check("R7", "flushed on falling mode bit", flags_o, TXE | RXE);
    tx_write(8'h77);
    tx_take(1'b0);
    check("R7", "next pop after flush", tx_pop_data_o, 8'h77);
  endtask

  task automatic t_rx_fifo();
    fifo_en_i = 1'b1; tick();
    for (int i = 0; i < 16; i++) rx_put(12'(i * 37 + 12'h100));
    check("R4", "rx full at 16", flags_o, TXE | RXF);
    check("R10", "no overrun yet", overrun_o, 0);
    rx_put(12'hFFF);
    check("R10", "overrun on discarded push", overrun_o, 1);
    for (int i = 0; i < 16; i++) begin
      rx_take();
      check("R12", "rx read order", rx_rdata_o, 12'(i * 37 + 12'h100));
    end
    check("R4", "rx empty after drain", flags_o, TXE | RXE);
    check("R10", "overrun sticky", overrun_o, 1);
    ovr_clr_i = 1'b1; tick(); ovr_clr_i = 1'b0;
    check("R10", "overrun cleared", overrun_o, 0);
  endtask

  task automatic t_rx_single();
    fifo_en_i = 1'b0; tick();
    rx_put(12'h3C4);
    check("R4", "single rx full", flags_o, TXE | RXF);
    rx_put(12'h222);
    check("R10", "single overrun", overrun_o, 1);
    rx_take();
    check("R4", "single rx data kept", rx_rdata_o, 12'h3C4);
    check("R4", "single rx empty", flags_o, TXE | RXE);
    ovr_clr_i = 1'b1; rx_push_i = 1'b1; rx_push_data_i = 12'h0AA; tick();
    ovr_clr_i = 1'b0; rx_push_i = 1'b0;
    check("R10", "clear with accepted push", overrun_o, 0);
    rx_take();
    check("R12", "accepted after clear", rx_rdata_o, 12'h0AA);
  endtask

  task automatic t_rx_empty_read();
    rx_take();
    check("R9", "rdata held on empty read", rx_rdata_o, 12'h0AA);
    check("R9", "flags unchanged on empty read", flags_o, TXE | RXE);
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    t_reset();
    t_tx_fifo();
    t_tx_single();
    t_shift();
    t_flush();
    t_rx_fifo();
    t_rx_single();
    t_rx_empty_read();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule